// File: doc/BRIEF.md
# Flash Transfer Data-Length Counter

This block sits in the data phase of a quad-SPI flash controller. Software programs a 32-bit length word through a write port. The word holds the byte count minus one. When a transfer starts, the block loads its own down-counter from that word. The serial engine reports each finished byte, and the block raises a last-byte flag during the final byte. One cycle after that byte it emits a single-cycle completion pulse.

Several modes alter the count. In dual-flash operation the lowest bit of the length is forced to one, so every access moves an even number of bytes. Status-polling transfers are limited to four bytes. An all-ones length in an indirect mode means open length. Such a transfer ends when the byte address reaches the last location of the flash, whose size comes from a size code. At the largest size code it never ends. In memory-mapped mode the length plays no part and no transfer is counted.

Top module: `xfer_len_ctr`

## Requirements
- R1: After reset the length readback is 0, and `lastByte` and `done` are low.
- R2: A stored length L (not all ones) in indirect write (`fnMode`=2'b00) or indirect read (2'b01) makes the transfer last exactly L+1 byte strobes.
- R3: `lastByte` is high while a transfer is running and the current byte is its final byte. Otherwise it is low.
- R4: `done` rises in the cycle after the clock edge that accepts the final byte strobe, and it is high for exactly one cycle.
- R5: A length write issued while `busy` is high leaves the stored length unchanged.
- R6: With `dualFlash` high, bit 0 of the length reads back as 1 and counts as 1 whatever was written. A written 4 therefore gives a readback of 5 and a 6-byte transfer.
- R7: In status-polling mode (`fnMode`=2'b11) a length above 3 acts as 3, so the transfer lasts 4 bytes. Smaller lengths act unchanged.
- R8: An all-ones length in an indirect mode runs until the byte strobe whose `byteAddr` equals 2^(`sizeCode`+1)-1. That strobe is the final byte.
- R9: An all-ones length in an indirect mode with `sizeCode`=31 never raises `lastByte` or `done`.
- R10: In memory-mapped mode (`fnMode`=2'b10) a start is ignored, and `lastByte` and `done` stay low.
- R11: A start while a transfer is running is ignored, and the running count continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lenWrEn | input | 1 | Length write strobe |
| lenWrData | input | 32 | Length value to write (bytes minus one) |
| busy | input | 1 | Controller busy, blocks length writes |
| fnMode | input | 2 | 00 indirect write, 01 indirect read, 10 memory-mapped, 11 status polling |
| dualFlash | input | 1 | Dual-flash operation |
| sizeCode | input | 5 | Flash size code, size = 2^(code+1) bytes |
| start | input | 1 | Begin the data phase |
| byteDone | input | 1 | One data byte finished |
| byteAddr | input | 32 | Address of the current byte |
| lenRdData | output | 32 | Length readback, as the counter sees it |
| lastByte | output | 1 | Current byte is the final one |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions assume that `fnMode`, `dualFlash` and `sizeCode` stay constant while a transfer is running. They also assume that `byteDone` arrives only after a start has been accepted, and that during an open-length transfer `byteAddr` rises with each byte. The stimulus changes modes and the size code only while the counter is idle. It leaves a never-ending transfer only by applying reset, and it drives byte addresses in rising order starting below the end address.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  typedef enum logic [1:0] {
    MODE_IND_WR = 2'b00,
    MODE_IND_RD = 2'b01,
    MODE_MEMMAP = 2'b10,
    MODE_POLL   = 2'b11
  } fn_mode_e;

  typedef struct packed {
    logic load;
    logic dec;
  } ctr_strobe_t;
endpackage

// File: rtl/xlc_datapath.sv
module xlc_datapath
  import xlc_pkg::*;
#(
  parameter int LEN_W    = 32,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 5,
  parameter int POLL_MAX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic              busy,
  input  logic [1:0]        fnMode,
  input  logic              dualFlash,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [ADDR_W-1:0] byteAddr,
  input  ctr_strobe_t       strobes,
  output logic [LEN_W-1:0]  lenRdData,
  output logic              isLast,
  output logic              runsForever
);
  localparam logic [SIZE_W-1:0] SIZE_MAX = SIZE_W'((1 << SIZE_W) - 1);
  localparam logic [LEN_W-1:0]  POLL_LIM = LEN_W'(POLL_MAX);

  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  lenView;
  logic [LEN_W-1:0]  lenEff;
  logic [LEN_W-1:0]  remaining;
  logic              unbounded;
  logic              isPoll;
  logic              isIndirect;
  logic              openLen;
  logic              sizeIsMax;
  logic [SIZE_W:0]   shiftAmt;
  logic [ADDR_W:0]   sizeBytes;
  logic [ADDR_W-1:0] endAddr;

  // Length register, locked while busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lenReg <= '0;
    else if (lenWrEn && !busy) lenReg <= lenWrData;
  end

  // Dual-flash forces an odd length code (even byte count)
  assign lenView    = {lenReg[LEN_W-1:1], lenReg[0] | dualFlash};
  assign lenRdData  = lenView;
  assign isPoll     = (fn_mode_e'(fnMode) == MODE_POLL);
  assign isIndirect = (fn_mode_e'(fnMode) == MODE_IND_WR) || (fn_mode_e'(fnMode) == MODE_IND_RD);
  assign lenEff     = (isPoll && (lenView > POLL_LIM)) ? POLL_LIM : lenView;
  assign openLen    = isIndirect && (&lenView);

  // Remaining byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      unbounded <= 1'b0;
    end else if (strobes.load) begin
      remaining <= lenEff;
      unbounded <= openLen;
    end else if (strobes.dec) begin
      remaining <= remaining - 1'b1;
    end
  end

  // End-of-flash address: 2^(code+1) - 1
  assign shiftAmt    = {1'b0, sizeCode} + 1'b1;
  assign sizeBytes   = (ADDR_W + 1)'(1) << shiftAmt;
  assign endAddr     = ADDR_W'(sizeBytes - 1'b1);
  assign sizeIsMax   = (sizeCode == SIZE_MAX);
  assign runsForever = unbounded && sizeIsMax;
  assign isLast      = unbounded ? (!sizeIsMax && (byteAddr == endAddr)) : (remaining == '0);

  p_busy_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lenReg));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dec && !unbounded) |-> (remaining != '0));

  p_poll_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && isPoll) |=> (remaining <= POLL_LIM));
endmodule

// File: rtl/xlc_ctrl.sv
module xlc_ctrl
  import xlc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        byteDone,
  input  logic [1:0]  fnMode,
  input  logic        isLast,
  input  logic        runsForever,
  output ctr_strobe_t strobes,
  output logic        lastByte,
  output logic        done
);
  logic active;
  logic finish;

  assign lastByte     = active && isLast;
  assign strobes.load = start && !active && (fn_mode_e'(fnMode) != MODE_MEMMAP);
  assign strobes.dec  = active && byteDone && !isLast;
  assign finish       = active && byteDone && isLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (strobes.load)  active <= 1'b1;
      else if (finish)   active <= 1'b0;
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lastByte && byteDone) |=> done);

  p_forever_r9: assert property (@(posedge clk) disable iff (!rstN)
    (active && runsForever) |=> active);

  p_memmap_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!active && fn_mode_e'(fnMode) == MODE_MEMMAP) |=> !active);
endmodule

// File: rtl/xfer_len_ctr.sv
module xfer_len_ctr
  import xlc_pkg::*;
#(
  parameter int LEN_W    = 32,
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 5,
  parameter int POLL_MAX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic              busy,
  input  logic [1:0]        fnMode,
  input  logic              dualFlash,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic              start,
  input  logic              byteDone,
  input  logic [ADDR_W-1:0] byteAddr,
  output logic [LEN_W-1:0]  lenRdData,
  output logic              lastByte,
  output logic              done
);
  ctr_strobe_t strobes;
  logic        isLast;
  logic        runsForever;

  xlc_datapath #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .POLL_MAX(POLL_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .busy(busy), .fnMode(fnMode), .dualFlash(dualFlash), .sizeCode(sizeCode),
    .byteAddr(byteAddr), .strobes(strobes), .lenRdData(lenRdData),
    .isLast(isLast), .runsForever(runsForever)
  );

  xlc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteDone(byteDone),
    .fnMode(fnMode), .isLast(isLast), .runsForever(runsForever),
    .strobes(strobes), .lastByte(lastByte), .done(done)
  );
endmodule

// File: tb/tb_xfer_len_ctr.sv
module tb_xfer_len_ctr;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lenWrEn = 1'b0;
  logic [31:0] lenWrData = '0;
  logic        busy = 1'b0;
  logic [1:0]  fnMode = 2'b01;
  logic        dualFlash = 1'b0;
  logic [4:0]  sizeCode = 5'd3;
  logic        start = 1'b0;
  logic        byteDone = 1'b0;
  logic [31:0] byteAddr = '0;
  logic [31:0] lenRdData;
  logic        lastByte;
  logic        done;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string curReq = "R1";

  xfer_len_ctr dut (
    .clk(clk), .rstN(rstN), .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .busy(busy), .fnMode(fnMode), .dualFlash(dualFlash), .sizeCode(sizeCode),
    .start(start), .byteDone(byteDone), .byteAddr(byteAddr),
    .lenRdData(lenRdData), .lastByte(lastByte), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] mLen;
  logic        mActive, mUnb, mDone;
  longint      mRem;

  function automatic logic [31:0] mView();
    return dualFlash ? (mLen | 32'd1) : mLen;
  endfunction

  function automatic logic mLastF();
    longint endA;
    endA = (64'd1 << (int'(sizeCode) + 1)) - 1;
    if (!mActive) return 1'b0;
    if (mUnb) return (sizeCode != 5'd31) && (longint'(byteAddr) == endA);
    return mRem == 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLen <= '0; mActive <= 1'b0; mUnb <= 1'b0; mDone <= 1'b0; mRem <= 0;
    end else begin
      logic [31:0] v;
      longint      eff;
      logic        lst;
      lst = mLastF();
      v   = mView();
      eff = longint'(v);
      if (fnMode == 2'b11 && eff > 3) eff = 3;
      mDone <= mActive && byteDone && lst;
      if (mActive && byteDone) begin
        if (lst) mActive <= 1'b0;
        else     mRem <= mRem - 1;
      end else if (start && !mActive && fnMode != 2'b10) begin
        mActive <= 1'b1;
        mRem    <= eff;
        mUnb    <= (fnMode < 2'b10) && (v == 32'hFFFF_FFFF);
      end
      if (lenWrEn && !busy) mLen <= lenWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "model lastByte", {31'd0, lastByte}, {31'd0, mLastF()});
      chk(curReq, "model done", {31'd0, done}, {31'd0, mDone});
      chk(curReq, "model readback", lenRdData, mView());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeLen(logic [31:0] d);
    tick(); lenWrEn = 1'b1; lenWrData = d;
    tick(); lenWrEn = 1'b0;
  endtask

  task automatic pulseStart();
    tick(); start = 1'b1;
    tick(); start = 1'b0;
  endtask

  task automatic pulseByte(logic [31:0] a);
    tick(); byteDone = 1'b1; byteAddr = a;
    tick(); byteDone = 1'b0;
  endtask

  // Returns number of byte strobes until done, or -1
  task automatic xfer(int maxB, logic [31:0] a0, output int got);
    got = -1;
    pulseStart();
    for (int i = 0; i < maxB; i++) begin
      pulseByte(a0 + 32'(i));
      if (done) begin got = i + 1; break; end
    end
  endtask

  task automatic doReset();
    tick(); rstN = 1'b0;
    tick(); tick(); rstN = 1'b1;
    #1;
  endtask

  initial begin
    int got;
    #2; tick(); tick(); rstN = 1'b1; #1;
    curReq = "R1";
    chk("R1", "reset readback", lenRdData, 32'd0);
    chk("R1", "reset done", {31'd0, done}, 32'd0);
    chk("R1", "reset lastByte", {31'd0, lastByte}, 32'd0);

    curReq = "R2"; fnMode = 2'b01;
    xfer(10, 0, got); chk("R2", "L=0 byte count", 32'(got), 32'd1);
    writeLen(32'd5);
    xfer(20, 0, got); chk("R2", "L=5 byte count", 32'(got), 32'd6);
    fnMode = 2'b00;
    writeLen(32'd2);
    xfer(20, 0, got); chk("R2", "write mode L=2 byte count", 32'(got), 32'd3);

    curReq = "R3"; fnMode = 2'b01;
    writeLen(32'd1);
    pulseStart();
    chk("R3", "lastByte on first of two", {31'd0, lastByte}, 32'd0);
    pulseByte(0);
    chk("R3", "lastByte on final", {31'd0, lastByte}, 32'd1);
    curReq = "R4";
    pulseByte(1);
    chk("R4", "done after final", {31'd0, done}, 32'd1);
    chk("R3", "lastByte after finish", {31'd0, lastByte}, 32'd0);
    tick();
    chk("R4", "done one cycle", {31'd0, done}, 32'd0);

    curReq = "R5";
    writeLen(32'd4);
    chk("R5", "readback before busy", lenRdData, 32'd4);
    busy = 1'b1;
    writeLen(32'd9);
    busy = 1'b0; #1;
    chk("R5", "readback after busy write", lenRdData, 32'd4);

    curReq = "R6"; dualFlash = 1'b1; #1;
    chk("R6", "dual readback bit0", lenRdData, 32'd5);
    xfer(20, 0, got); chk("R6", "dual byte count", 32'(got), 32'd6);
    dualFlash = 1'b0;

    curReq = "R7"; fnMode = 2'b11;
    writeLen(32'd10);
    xfer(20, 0, got); chk("R7", "poll clamp count", 32'(got), 32'd4);
    writeLen(32'd2);
    xfer(20, 0, got); chk("R7", "poll small count", 32'(got), 32'd3);

    curReq = "R8"; fnMode = 2'b01; sizeCode = 5'd3;
    writeLen(32'hFFFF_FFFF);
    xfer(40, 32'd10, got); chk("R8", "end of 16-byte flash", 32'(got), 32'd6);
    sizeCode = 5'd4;
    xfer(60, 32'd20, got); chk("R8", "end of 32-byte flash", 32'(got), 32'd12);

    curReq = "R11"; writeLen(32'd2);
    pulseStart();
    pulseByte(0);
    pulseStart();
    pulseByte(1);
    chk("R11", "no done after two", {31'd0, done}, 32'd0);
    pulseByte(2);
    chk("R11", "done after three", {31'd0, done}, 32'd1);

    curReq = "R10"; fnMode = 2'b10; writeLen(32'd0);
    xfer(5, 0, got); chk("R10", "memmap no done", 32'(got), 32'hFFFF_FFFF);
    chk("R10", "memmap lastByte", {31'd0, lastByte}, 32'd0);

    curReq = "R9"; fnMode = 2'b01; sizeCode = 5'd31;
    writeLen(32'hFFFF_FFFF);
    xfer(80, 32'hFFFF_FFD0, got); chk("R9", "forever no done", 32'(got), 32'hFFFF_FFFF);
    chk("R9", "forever lastByte", {31'd0, lastByte}, 32'd0);

    curReq = "R1";
    doReset();
    chk("R1", "second reset readback", lenRdData, 32'd0);
    chk("R1", "second reset lastByte", {31'd0, lastByte}, 32'd0);
    sizeCode = 5'd3;
    xfer(10, 0, got); chk("R2", "after reset L=0", 32'(got), 32'd1);

    tick(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule